// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Fill Flags

This block is a first-in first-out buffer for 18-bit words whose write side and read side run on unrelated clocks. Each side keeps its own pointer. The pointers cross to the other domain as Gray code through multi-stage synchronizers. Write-side status (full, half, almost-full) is derived in the write clock domain. Read-side status (empty, almost-empty) is derived in the read clock domain. The depth is a power of two set by a parameter.

The output timing style is chosen once, at master reset, from the level on `fwftSel`:
- **Standard style:** a word leaves only on an enabled read. The two main flags report empty and full.
- **Fall-through style:** the oldest word is presented on the output unprompted. The same two flags then report "word ready" and "space available".

The level of `ldSel` at master reset picks one of two preset thresholds for both programmable flags. While the buffer is running, holding `ldSel` high turns enabled writes into threshold loads taken from the data bus.

Further controls:
- A partial reset empties the buffer but keeps the thresholds and the timing style.
- A rewind request sends the read side back to storage location zero, so the words written since the last reset are replayed.

Top module: `dual_clk_flag_fifo`

## Requirements
- R1: While `mstRstN` is low, the buffer empties and `rdData` is cleared to 0. After release in standard style: `rdFlagN`=0, `wrFlagN`=1, `halfN`=1, `almostEmptyN`=0, `almostFullN`=1. After release in fall-through style: `rdFlagN`=1 and `wrFlagN`=0.
- R2: In standard style, a rising `rdClk` edge with `rdEn`=1 and `rdFlagN`=1 puts the oldest word on `rdData` after that edge. Words leave in write order. `rdFlagN`=0 means empty, and reads on an empty buffer change nothing.
- R3: In standard style, at most DEPTH words are held. `wrFlagN` is 0 when full, and writes attempted while full are discarded.
- R4: In fall-through style, the oldest word appears on `rdData` with `rdFlagN`=0 and no read request. A `rdClk` edge with `rdEn`=1 while `rdFlagN`=0 moves to the next word. Capacity is DEPTH+1, counting the word held at the output. `wrFlagN`=0 means space is available.
- R5: The timing style is the `fwftSel` level sampled at `wrClk` edges while `mstRstN` is low. Its level at any other time, including during a partial reset, has no effect.
- R6: `halfN` is 0 exactly when the write-side occupancy exceeds DEPTH/2. In fall-through style, write-side occupancy excludes the word held at the output.
- R7: `almostEmptyN` is 0 exactly when the read-side occupancy is at or below the empty threshold. Read-side occupancy includes the word held at the output.
- R8: `almostFullN` is 0 exactly when DEPTH minus the write-side occupancy is at or below the full threshold.
- R9: At master reset, both thresholds take `DEF_LO` if `ldSel` is low and `DEF_HI` if it is high. The parameter defaults are 0x007F and 0x03FF.
- R10: With `ldSel`=1, enabled writes store no data. The first such write loads the empty threshold from `wrData[ADDR_W:0]`, and the second loads the full threshold.
- R11: A partial reset (`partRstN` low) empties the buffer and keeps both thresholds and the timing style.
- R12: A `rdClk` edge with `rewind`=1 returns the read side to location 0, and subsequent reads replay from the first word written since reset. In fall-through style, `rdFlagN` is 1 after that edge and the first word is presented after the following edge.
- R13: A `wrClk` edge with `wrEn`=0 stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write clock |
| rdClk | input | 1 | Read clock |
| mstRstN | input | 1 | Master reset, active low |
| partRstN | input | 1 | Partial reset, active low |
| fwftSel | input | 1 | Timing style selected at master reset (1 = fall-through) |
| ldSel | input | 1 | Threshold default select at master reset; threshold load enable in operation |
| wrEn | input | 1 | Write enable |
| wrData | input | DATA_W | Write data and threshold load value |
| rdEn | input | 1 | Read enable |
| rewind | input | 1 | Rewind request, read domain |
| rdData | output | DATA_W | Output word register |
| rdFlagN | output | 1 | Standard: low when empty. Fall-through: low when a word is ready |
| wrFlagN | output | 1 | Standard: low when full. Fall-through: low when space is available |
| halfN | output | 1 | Low when more than half full |
| almostEmptyN | output | 1 | Low at or below the empty threshold |
| almostFullN | output | 1 | Low when free space is at or below the full threshold |

## Verification
The hardest situation to reach is the fall-through style filled to DEPTH+1. This requires a word sitting in the output register while the write side still counts every RAM slot as taken, so the read-side and write-side occupancies differ by one. The bench selects fall-through at master reset, writes one word and lets it reach the output. It then keeps writing without reading until the space flag drops, and checks each flag against the two occupancies. The rewind case also needs care: the bench fills fewer than DEPTH words before rewinding, so location zero still holds the first word.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  // Strobes from control to datapath.
  typedef struct packed {
    logic memWr;    // store wrData into RAM (write domain)
    logic ldEmpty;  // load empty threshold (write domain)
    logic ldFull;   // load full threshold (write domain)
    logic outLoad;  // move RAM word into output register (read domain)
  } strobe_t;

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) pipe[s] <= '0;
          else       pipe[s] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) pipe[s] <= '0;
          else       pipe[s] <= pipe[s-1];
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/dcf_ctrl.sv
module dcf_ctrl
  import dcf_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int SYNC_STGS = 2
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              mstRstN,
  input  logic              fwftSel,
  input  logic              ldSel,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              rewind,
  input  logic [ADDR_W:0]   emptyOffs,
  input  logic [ADDR_W:0]   fullOffs,
  output strobe_t           stb,
  output logic [ADDR_W-1:0] wAddr,
  output logic [ADDR_W-1:0] rAddr,
  output logic              rdFlagN,
  output logic              wrFlagN,
  output logic              halfN,
  output logic              almostEmptyN,
  output logic              almostFullN
);
  localparam int PTR_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);
  localparam logic [PTR_W-1:0] HALF_P  = PTR_W'(DEPTH / 2);

  typedef logic [PTR_W-1:0] ptr_t;

  function automatic ptr_t toGray(ptr_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic ptr_t fromGray(ptr_t g);
    ptr_t b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // Timing style, captured while master reset is held.
  logic fwftMode;
  always_ff @(posedge wrClk)
    if (!mstRstN) fwftMode <= fwftSel;

  // ---------------- write domain ----------------
  ptr_t wrBin, wrGray, rdGraySync, rdBinW, wCount, wFree;
  logic wFull, loadSel;

  dcf_sync #(.W(PTR_W), .STAGES(SYNC_STGS)) rdToWr_i (
    .clk(wrClk), .rstN(rstN), .d(rdGray), .q(rdGraySync));

  assign rdBinW = fromGray(rdGraySync);
  assign wCount = wrBin - rdBinW;
  assign wFree  = DEPTH_P - wCount;
  assign wFull  = (wCount == DEPTH_P);

  assign stb.memWr   = wrEn && !ldSel && !wFull;
  assign stb.ldEmpty = wrEn && ldSel && !loadSel;
  assign stb.ldFull  = wrEn && ldSel && loadSel;
  assign wAddr       = wrBin[ADDR_W-1:0];

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrBin   <= '0;
      wrGray  <= '0;
      loadSel <= 1'b0;
    end else begin
      if (stb.memWr) begin
        wrBin  <= wrBin + 1'b1;
        wrGray <= toGray(wrBin + 1'b1);
      end
      if (!ldSel)     loadSel <= 1'b0;
      else if (wrEn)  loadSel <= ~loadSel;
    end
  end

  assign wrFlagN     = fwftMode ? wFull : ~wFull;
  assign halfN       = ~(wCount > HALF_P);
  assign almostFullN = ~(wFree <= fullOffs);

  // ---------------- read domain ----------------
  ptr_t rdBin, rdGray, wrGraySync, wrBinR, ramCount, rCount;
  logic ramEmpty, outValid, take;

  dcf_sync #(.W(PTR_W), .STAGES(SYNC_STGS)) wrToRd_i (
    .clk(rdClk), .rstN(rstN), .d(wrGray), .q(wrGraySync));

  assign wrBinR   = fromGray(wrGraySync);
  assign ramCount = wrBinR - rdBin;
  assign ramEmpty = (ramCount == '0);

  always_comb begin
    if (rewind)        take = 1'b0;
    else if (fwftMode) take = !ramEmpty && (!outValid || rdEn);
    else               take = rdEn && !ramEmpty;
  end

  assign stb.outLoad = take;
  assign rAddr       = rdBin[ADDR_W-1:0];

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdBin    <= '0;
      rdGray   <= '0;
      outValid <= 1'b0;
    end else begin
      if (rewind) begin
        rdBin  <= '0;
        rdGray <= '0;
      end else if (take) begin
        rdBin  <= rdBin + 1'b1;
        rdGray <= toGray(rdBin + 1'b1);
      end
      if (!fwftMode || rewind) outValid <= 1'b0;
      else if (take)           outValid <= 1'b1;
      else if (rdEn)           outValid <= 1'b0;
    end
  end

  assign rCount       = ramCount + ptr_t'(fwftMode && outValid);
  assign rdFlagN      = fwftMode ? ~outValid : ~ramEmpty;
  assign almostEmptyN = ~(rCount <= emptyOffs);

  // ---------------- assertions ----------------
  a_r3_no_overflow: assert property (@(posedge wrClk) disable iff (!rstN)
    wCount <= DEPTH_P);
  a_r2_no_underflow: assert property (@(posedge rdClk) disable iff (!rstN)
    ramCount <= DEPTH_P);
  a_r10_load_no_data: assert property (@(posedge wrClk) disable iff (!rstN)
    (ldSel && wrEn) |=> $stable(wrBin));
  a_r13_idle_write: assert property (@(posedge wrClk) disable iff (!rstN)
    !wrEn |=> $stable(wrBin));
  a_r4_ready_hold: assert property (@(posedge rdClk) disable iff (!rstN)
    (fwftMode && outValid && !rdEn && !rewind) |=> outValid);
endmodule

// File: rtl/dcf_dpath.sv
module dcf_dpath
  import dcf_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 10,
  parameter int DEF_LO = 'h007F,
  parameter int DEF_HI = 'h03FF
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              mstRstN,
  input  logic              ldSel,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] wAddr,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W:0]   emptyOffs,
  output logic [ADDR_W:0]   fullOffs
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int OFFS_W = ADDR_W + 1;
  localparam logic [OFFS_W-1:0] LO_P = OFFS_W'(DEF_LO);
  localparam logic [OFFS_W-1:0] HI_P = OFFS_W'(DEF_HI);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wrClk)
    if (stb.memWr) mem[wAddr] <= wrData;

  always_ff @(posedge wrClk) begin
    if (!mstRstN) begin
      emptyOffs <= ldSel ? HI_P : LO_P;
      fullOffs  <= ldSel ? HI_P : LO_P;
    end else begin
      if (stb.ldEmpty) emptyOffs <= wrData[OFFS_W-1:0];
      if (stb.ldFull)  fullOffs  <= wrData[OFFS_W-1:0];
    end
  end

  always_ff @(posedge rdClk or negedge rstN)
    if (!rstN)            rdData <= '0;
    else if (stb.outLoad) rdData <= mem[rAddr];

  a_r11_offs_hold: assert property (@(posedge wrClk) disable iff (!mstRstN)
    !(stb.ldEmpty || stb.ldFull) |=> ($stable(emptyOffs) && $stable(fullOffs)));
endmodule

// File: rtl/dual_clk_flag_fifo.sv
module dual_clk_flag_fifo
  import dcf_pkg::*;
#(
  parameter int DATA_W    = 18,
  parameter int ADDR_W    = 10,
  parameter int SYNC_STGS = 2,
  parameter int DEF_LO    = 'h007F,
  parameter int DEF_HI    = 'h03FF
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              mstRstN,
  input  logic              partRstN,
  input  logic              fwftSel,
  input  logic              ldSel,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic              rewind,
  output logic [DATA_W-1:0] rdData,
  output logic              rdFlagN,
  output logic              wrFlagN,
  output logic              halfN,
  output logic              almostEmptyN,
  output logic              almostFullN
);
  logic              rstN;
  strobe_t           stb;
  logic [ADDR_W-1:0] wAddr, rAddr;
  logic [ADDR_W:0]   emptyOffs, fullOffs;

  assign rstN = mstRstN & partRstN;

  dcf_ctrl #(.ADDR_W(ADDR_W), .SYNC_STGS(SYNC_STGS)) ctrl_i (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .mstRstN(mstRstN),
    .fwftSel(fwftSel), .ldSel(ldSel), .wrEn(wrEn), .rdEn(rdEn), .rewind(rewind),
    .emptyOffs(emptyOffs), .fullOffs(fullOffs), .stb(stb),
    .wAddr(wAddr), .rAddr(rAddr), .rdFlagN(rdFlagN), .wrFlagN(wrFlagN),
    .halfN(halfN), .almostEmptyN(almostEmptyN), .almostFullN(almostFullN));

  dcf_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEF_LO(DEF_LO), .DEF_HI(DEF_HI)) dpath_i (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .mstRstN(mstRstN), .ldSel(ldSel),
    .stb(stb), .wAddr(wAddr), .rAddr(rAddr), .wrData(wrData), .rdData(rdData),
    .emptyOffs(emptyOffs), .fullOffs(fullOffs));
endmodule

// File: tb/dual_clk_flag_fifo_tb_top.sv
module dual_clk_flag_fifo_tb_top;
  localparam int DW = 18, AW = 4, DEPTH = 16, LO = 2, HI = 5;

  logic wrClk = 0, rdClk = 0;
  always #10 wrClk = ~wrClk;   // 50 MHz
  always #13 rdClk = ~rdClk;

  logic mstRstN = 0, partRstN = 1, fwftSel = 0, ldSel = 0;
  logic wrEn = 0, rdEn = 0, rewind = 0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic rdFlagN, wrFlagN, halfN, almostEmptyN, almostFullN;

  dual_clk_flag_fifo #(.DATA_W(DW), .ADDR_W(AW), .DEF_LO(LO), .DEF_HI(HI)) dut_i (
    .wrClk(wrClk), .rdClk(rdClk), .mstRstN(mstRstN), .partRstN(partRstN),
    .fwftSel(fwftSel), .ldSel(ldSel), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .rewind(rewind), .rdData(rdData), .rdFlagN(rdFlagN), .wrFlagN(wrFlagN),
    .halfN(halfN), .almostEmptyN(almostEmptyN), .almostFullN(almostFullN));

  // Reference model
  int compared = 0, mismatched = 0;
  logic [DW-1:0] hist[$];
  int rdIdx = 0;
  bit mFwft = 0, ldPhase = 0, pendValid = 0, done = 0;
  int mEmpty = LO, mFull = LO;
  logic [DW-1:0] pendExp = '0;
  int seqVal = 'h100;

  function automatic int total();
    return hist.size() - rdIdx;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr1(input logic [DW-1:0] d, input bit en);
    bit f;
    @(negedge wrClk);
    wrEn = en; wrData = d; f = wrFlagN;
    @(posedge wrClk);
    if (en) begin
      if (ldSel) begin
        if (!ldPhase) mEmpty = int'(d[AW:0]); else mFull = int'(d[AW:0]);
        ldPhase = !ldPhase;
      end else if (mFwft ? !f : f) hist.push_back(d);
    end
  endtask

  task automatic wrMany(input int n);
    for (int i = 0; i < n; i++) begin wr1(DW'(seqVal), 1'b1); seqVal++; end
    @(negedge wrClk); wrEn = 0;
  endtask

  task automatic rd1(input bit en);
    bit s;
    @(negedge rdClk);
    if (pendValid) begin chk("R2", "read word", 32'(rdData), 32'(pendExp)); pendValid = 0; end
    s = rdFlagN;
    if (!mFwft && s) chk("R2", "not-empty implies data", 32'(total() > 0), 1);
    if (mFwft && !s) begin
      chk("R4", "ready implies data", 32'(total() > 0), 1);
      if (total() > 0) chk("R4", "presented word", 32'(rdData), 32'(hist[rdIdx]));
    end
    rdEn = en;
    @(posedge rdClk);
    if (en && !mFwft && s) begin pendExp = hist[rdIdx]; pendValid = 1; rdIdx++; end
    if (en && mFwft && !s) rdIdx++;
  endtask

  task automatic rdMany(input int n);
    for (int i = 0; i < n; i++) rd1(1'b1);
    rd1(1'b0);
  endtask

  task automatic settle();
    @(negedge wrClk); wrEn = 0;
    rd1(1'b0);
    repeat (8) @(posedge rdClk);
    repeat (8) @(posedge wrClk);
    @(negedge rdClk);
  endtask

  task automatic flagCheck(input string req);
    int tot, wc;
    settle();
    tot = total();
    wc  = (mFwft && tot > 0) ? tot - 1 : tot;
    chk(req, "rdFlagN", 32'(rdFlagN), mFwft ? 32'(tot == 0) : 32'(tot != 0));
    chk(req, "wrFlagN", 32'(wrFlagN), mFwft ? 32'(wc == DEPTH) : 32'(wc != DEPTH));
    chk(req, "halfN", 32'(halfN), 32'(!(wc > DEPTH / 2)));
    chk(req, "almostEmptyN", 32'(almostEmptyN), 32'(!(tot <= mEmpty)));
    chk(req, "almostFullN", 32'(almostFullN), 32'(!((DEPTH - wc) <= mFull)));
  endtask

  task automatic masterReset(input bit fw, input bit ld);
    @(negedge wrClk);
    mstRstN = 0; fwftSel = fw; ldSel = ld; rdEn = 0; wrEn = 0;
    repeat (4) @(negedge wrClk);
    mstRstN = 1; ldSel = 0;
    hist.delete(); rdIdx = 0; mFwft = fw; ldPhase = 0; pendValid = 0;
    mEmpty = ld ? HI : LO; mFull = ld ? HI : LO;
  endtask

  task automatic partialReset();
    @(negedge wrClk);
    partRstN = 0; fwftSel = !mFwft; rdEn = 0; wrEn = 0;
    repeat (4) @(negedge wrClk);
    partRstN = 1;
    hist.delete(); rdIdx = 0; ldPhase = 0; pendValid = 0;
  endtask

  task automatic rewindOp();
    @(negedge rdClk);
    if (pendValid) begin chk("R2", "read word", 32'(rdData), 32'(pendExp)); pendValid = 0; end
    rdEn = 0; rewind = 1;
    @(posedge rdClk);
    rdIdx = 0;
    @(negedge rdClk);
    rewind = 0;
    if (mFwft) begin
      chk("R12", "ready dropped after rewind", 32'(rdFlagN), 1);
      @(negedge rdClk);
      chk("R12", "ready one edge later", 32'(rdFlagN), 0);
      chk("R12", "first word replayed", 32'(rdData), 32'(hist[0]));
    end
  endtask

  initial begin
    repeat (200000) @(posedge wrClk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    // R1 standard reset state
    masterReset(1'b0, 1'b0);
    flagCheck("R1");
    chk("R1", "rdData cleared", 32'(rdData), 0);

    // R13 disabled writes store nothing
    for (int i = 0; i < 4; i++) wr1(DW'(i + 'h55), 1'b0);
    flagCheck("R13");

    // R2 / R7 basic order and empty-threshold
    wrMany(5);
    flagCheck("R7");
    rdMany(3);
    flagCheck("R7");
    rdMany(4);
    flagCheck("R2");

    // R6 / R8 / R3 fill in steps
    wrMany(8);  flagCheck("R6");
    wrMany(1);  flagCheck("R6");
    wrMany(5);  flagCheck("R8");
    wrMany(5);  flagCheck("R3");
    chk("R3", "words accepted", 32'(total()), DEPTH);
    rdMany(20);
    flagCheck("R3");

    // R2 streaming with both sides active
    fork
      wrMany(40);
      rdMany(70);
    join
    rdMany(DEPTH + 2);
    flagCheck("R2");

    // R10 threshold load
    @(negedge wrClk); ldSel = 1;
    wr1(DW'(3), 1'b1);
    wr1(DW'(6), 1'b1);
    @(negedge wrClk); ldSel = 0; wrEn = 0;
    flagCheck("R10");
    wrMany(3);  flagCheck("R10");
    wrMany(7);  flagCheck("R10");

    // R11 partial reset keeps thresholds and style
    partialReset();
    flagCheck("R11");
    wrMany(3);  flagCheck("R11");

    // R12 rewind in standard style
    rdMany(3);
    rewindOp();
    rdMany(4);
    flagCheck("R12");

    // R5 / R9 fall-through with high defaults
    masterReset(1'b1, 1'b1);
    flagCheck("R5");
    wrMany(1);  flagCheck("R4");
    chk("R4", "word presented unprompted", 32'(rdData), 32'(hist[0]));
    wrMany(4);  flagCheck("R9");
    wrMany(1);  flagCheck("R9");
    wrMany(13); flagCheck("R4");
    chk("R4", "capacity", 32'(total()), DEPTH + 1);
    rdMany(20);
    flagCheck("R4");

    // R12 rewind in fall-through style
    partialReset();
    wrMany(5);  flagCheck("R12");
    rdMany(2);
    rewindOp();
    rdMany(7);
    flagCheck("R12");

    // R5 partial reset with the other style level does not change style
    partialReset();
    flagCheck("R5");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule